// File: doc/BRIEF.md
# Broadcast Scanline Column Capture

Each node in a linear processor array sits on a shared byte-wide broadcast bus. The image on that bus is streamed in raster order: one scanline after another, one byte per valid cycle. This block is the node's input filter. It counts the byte position within the current scanline and the index of that scanline. It compares the position against the slice of the row that the node owns, and it writes each owned byte into the node's local memory. The slice is set by a first column index, a number of columns and a number of bytes per pixel.

Writes land so that memory ends up column-major. Each owned byte has a slot number, which is its offset inside the slice, and that slot selects a vector region in memory. The row index selects the element inside the region. A node that owns several colour columns therefore ends with one vector per colour plane of every column it owns. Each vector has one entry per row. A strobe resynchronises the position at the start of a row. A frame strobe restarts the whole capture. A done flag reports that the configured number of rows has arrived.

Top module: `column_capture`

## Requirements
- R1: After reset the write strobe and the done flag are low, and the first accepted byte is treated as position 0 of row 0.
- R2: A bus byte is accepted only in a cycle where `bus_valid` is high. The position and row counters do not move in cycles without `bus_valid`, `row_start` or `frame_start`.
- R3: `row_start` forces the position to 0. A byte presented in the same cycle takes position 0. The row index is left unchanged.
- R4: An accepted byte at position p is written if and only if `cfg_col*cfg_bpp <= p < (cfg_col+cfg_ncols)*cfg_bpp`.
- R5: The write address is `cfg_base + (slot << ROW_W) + row`, where `slot = p - cfg_col*cfg_bpp` and ROW_W is 10 by default. With several bytes per pixel, consecutive planes of a pixel therefore occupy consecutive slots.
- R6: The written data equals the accepted bus byte. The write strobe, address and data appear one clock after the byte is accepted.
- R7: An accepted byte at position `cfg_row_bytes-1` wraps the position to 0 and increments the row index.
- R8: After the last byte of row `cfg_rows-1` is accepted, `done` is high from the next clock on and stays high until `frame_start`. No bytes are written while it is high.
- R9: `frame_start` clears the position, the row index and `done`. A byte presented in the same cycle is position 0 of row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_col | input | 10 | first column owned by this node |
| cfg_bpp | input | 2 | bytes per pixel (1 to 3) |
| cfg_ncols | input | 3 | number of consecutive columns owned |
| cfg_row_bytes | input | 12 | bytes per scanline |
| cfg_rows | input | 10 | scanlines per frame |
| cfg_base | input | 16 | base address of the node's vectors |
| frame_start | input | 1 | restart capture of a frame |
| row_start | input | 1 | scanline start, resets position |
| bus_valid | input | 1 | broadcast byte valid |
| bus_data | input | 8 | broadcast byte |
| mem_we | output | 1 | local memory write strobe |
| mem_addr | output | 16 | local memory write address |
| mem_wdata | output | 8 | local memory write data |
| done | output | 1 | configured rows received |

## Verification
The hardest situations to reach are those where the counters and the strobes disagree. In one, a `row_start` arrives in the middle of a row, so that owned positions are revisited at the same row index. In another, a `frame_start` cuts a frame short while the row index is non-zero. In a third, bytes keep streaming after `done`. The stimulus sends a truncated row and then resynchronises it. It restarts a frame partway through. It runs a frame of three-byte pixels across two owned columns and inserts idle gaps between bytes. After `done` it drives extra bytes. A scoreboard model that knows only the requirements predicts every write.

// File: rtl/capture_pkg.sv
package capture_pkg;
    localparam int POS_W_DEF  = 12;
    localparam int ROW_W_DEF  = 10;
    localparam int ADDR_W_DEF = 16;
    localparam int COL_W_DEF  = 10;
    localparam int BPP_W_DEF  = 2;
    localparam int NCOL_W_DEF = 3;
    localparam int DATA_W_DEF = 8;
endpackage

// File: rtl/capture_pos.sv
module capture_pos #(
    parameter int POS_W = capture_pkg::POS_W_DEF,
    parameter int ROW_W = capture_pkg::ROW_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             row_start,
    input  logic             bus_valid,
    input  logic [POS_W-1:0] cfg_row_bytes,
    input  logic [ROW_W-1:0] cfg_rows,
    output logic [POS_W-1:0] cur_pos,
    output logic [ROW_W-1:0] cur_row,
    output logic             accept,
    output logic             done
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [ROW_W-1:0] row;
        logic             done;
    } pos_state_t;

    pos_state_t st_q, st_d, eff;

    localparam logic [POS_W-1:0] ONE_P = POS_W'(1);
    localparam logic [ROW_W-1:0] ONE_R = ROW_W'(1);

    always_comb begin
        eff = st_q;
        if (frame_start) begin
            eff.pos  = '0;
            eff.row  = '0;
            eff.done = 1'b0;
        end else if (row_start) begin
            eff.pos = '0;
        end
        accept = bus_valid && !eff.done;
        st_d   = eff;
        if (accept) begin
            if (eff.pos == cfg_row_bytes - ONE_P) begin
                st_d.pos = '0;
                st_d.row = eff.row + ONE_R;
                if (eff.row == cfg_rows - ONE_R) begin
                    st_d.done = 1'b1;
                end
            end else begin
                st_d.pos = eff.pos + ONE_P;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_pos = eff.pos;
    assign cur_row = eff.row;
    assign done    = st_q.done;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && !row_start && !frame_start) |=> (st_q == $past(st_q)));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !frame_start) |=> st_q.done);

    p_frame_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !bus_valid) |=> (st_q.pos == '0 && st_q.row == '0 && !st_q.done));

    p_row_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_start && !frame_start && !bus_valid) |=> (st_q.pos == '0 && st_q.row == $past(st_q.row)));
endmodule

// File: rtl/capture_window.sv
module capture_window #(
    parameter int POS_W  = capture_pkg::POS_W_DEF,
    parameter int COL_W  = capture_pkg::COL_W_DEF,
    parameter int BPP_W  = capture_pkg::BPP_W_DEF,
    parameter int NCOL_W = capture_pkg::NCOL_W_DEF
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [COL_W-1:0]  cfg_col,
    input  logic [BPP_W-1:0]  cfg_bpp,
    input  logic [NCOL_W-1:0] cfg_ncols,
    output logic              hit,
    output logic [POS_W-1:0]  slot
);
    logic [POS_W-1:0] first_d;
    logic [POS_W-1:0] span_d;
    logic [POS_W-1:0] offs_d;

    always_comb begin
        first_d = POS_W'(cfg_col) * POS_W'(cfg_bpp);
        span_d  = POS_W'(cfg_ncols) * POS_W'(cfg_bpp);
        offs_d  = pos - first_d;
        hit     = (pos >= first_d) && (offs_d < span_d);
        slot    = offs_d;
    end
endmodule

// File: rtl/capture_wr.sv
module capture_wr #(
    parameter int POS_W  = capture_pkg::POS_W_DEF,
    parameter int ROW_W  = capture_pkg::ROW_W_DEF,
    parameter int ADDR_W = capture_pkg::ADDR_W_DEF,
    parameter int DATA_W = capture_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [POS_W-1:0]  slot,
    input  logic [ROW_W-1:0]  row,
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_state_t;

    wr_state_t wr_q, wr_d;

    always_comb begin
        wr_d      = wr_q;
        wr_d.we   = wr_en;
        if (wr_en) begin
            wr_d.addr = base + (ADDR_W'(slot) << ROW_W) + ADDR_W'(row);
            wr_d.data = data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign mem_we    = wr_q.we;
    assign mem_addr  = wr_q.addr;
    assign mem_wdata = wr_q.data;
endmodule

// File: rtl/column_capture.sv
module column_capture #(
    parameter int POS_W  = capture_pkg::POS_W_DEF,
    parameter int ROW_W  = capture_pkg::ROW_W_DEF,
    parameter int ADDR_W = capture_pkg::ADDR_W_DEF,
    parameter int COL_W  = capture_pkg::COL_W_DEF,
    parameter int BPP_W  = capture_pkg::BPP_W_DEF,
    parameter int NCOL_W = capture_pkg::NCOL_W_DEF,
    parameter int DATA_W = capture_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  cfg_col,
    input  logic [BPP_W-1:0]  cfg_bpp,
    input  logic [NCOL_W-1:0] cfg_ncols,
    input  logic [POS_W-1:0]  cfg_row_bytes,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              frame_start,
    input  logic              row_start,
    input  logic              bus_valid,
    input  logic [DATA_W-1:0] bus_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done
);
    logic [POS_W-1:0] cur_pos;
    logic [ROW_W-1:0] cur_row;
    logic             accept;
    logic             hit;
    logic [POS_W-1:0] slot;

    capture_pos #(.POS_W(POS_W), .ROW_W(ROW_W)) u_pos (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .row_start(row_start), .bus_valid(bus_valid),
        .cfg_row_bytes(cfg_row_bytes), .cfg_rows(cfg_rows),
        .cur_pos(cur_pos), .cur_row(cur_row), .accept(accept), .done(done)
    );

    capture_window #(.POS_W(POS_W), .COL_W(COL_W), .BPP_W(BPP_W), .NCOL_W(NCOL_W)) u_win (
        .pos(cur_pos), .cfg_col(cfg_col), .cfg_bpp(cfg_bpp), .cfg_ncols(cfg_ncols),
        .hit(hit), .slot(slot)
    );

    capture_wr #(.POS_W(POS_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept && hit), .slot(slot), .row(cur_row), .base(cfg_base), .data(bus_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    p_we_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(bus_valid));

    p_data_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == $past(bus_data)));

    p_no_write_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done) && !$past(frame_start)) |-> !mem_we);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_we && !done));
endmodule

// File: tb/test_column_capture.sv
`timescale 1ns/1ps
module test_column_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  cfg_col = '0;
    logic [1:0]  cfg_bpp = 2'd1;
    logic [2:0]  cfg_ncols = 3'd1;
    logic [11:0] cfg_row_bytes = 12'd8;
    logic [9:0]  cfg_rows = 10'd1;
    logic [15:0] cfg_base = '0;
    logic        frame_start = 1'b0;
    logic        row_start = 1'b0;
    logic        bus_valid = 1'b0;
    logic [7:0]  bus_data = '0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        done;

    int total = 0;
    int bad = 0;
    logic [23:0] expq[$];

    int m_pos = 0;
    int m_row = 0;
    bit m_done = 0;

    always #4 clk = ~clk;

    column_capture i_column_capture (
        .clk(clk), .rst_n(rst_n),
        .cfg_col(cfg_col), .cfg_bpp(cfg_bpp), .cfg_ncols(cfg_ncols),
        .cfg_row_bytes(cfg_row_bytes), .cfg_rows(cfg_rows), .cfg_base(cfg_base),
        .frame_start(frame_start), .row_start(row_start),
        .bus_valid(bus_valid), .bus_data(bus_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected writes (R4 R5 R6)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (expq.size() == 0) begin
                check(1'b0, "R4 unexpected write", {mem_addr, mem_wdata}, 0);
            end else begin
                logic [23:0] e;
                e = expq.pop_front();
                check({mem_addr, mem_wdata} == e, "R4/R5/R6 write", {mem_addr, mem_wdata}, e);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        frame_start = 0; row_start = 0; bus_valid = 0;
    endtask

    task automatic start_frame();
        @(negedge clk);
        frame_start = 1; row_start = 0; bus_valid = 0;
        m_pos = 0; m_row = 0; m_done = 0;
        @(negedge clk);
        frame_start = 0;
    endtask

    task automatic send(input logic [7:0] b, input bit rs);
        int first, span;
        @(negedge clk);
        frame_start = 0; row_start = rs; bus_valid = 1; bus_data = b;
        if (rs) m_pos = 0;
        if (!m_done) begin
            first = int'(cfg_col) * int'(cfg_bpp);
            span  = int'(cfg_ncols) * int'(cfg_bpp);
            if (m_pos >= first && m_pos < first + span)
                expq.push_back({16'(int'(cfg_base) + ((m_pos - first) << 10) + m_row), b});
            m_pos++;
            if (m_pos == int'(cfg_row_bytes)) begin
                m_pos = 0;
                m_row++;
                if (m_row == int'(cfg_rows)) m_done = 1;
            end
        end
    endtask

    task automatic send_row(input int r, input bit gaps);
        for (int x = 0; x < int'(cfg_row_bytes); x++) begin
            send(8'((r * 37 + x * 5 + 1) & 8'hff), x == 0);
            if (gaps && (x % 3 == 1)) idle();
        end
    endtask

    task automatic drain_and_check(input string req);
        idle(); idle();
        check(expq.size() == 0, req, expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_we == 0, "R1 we after reset", mem_we, 0);
        check(done == 0, "R1 done after reset", done, 0);
        rst_n = 1;
        idle();
        check(mem_we == 0 && done == 0, "R1 idle after reset", {mem_we, done}, 0);

        // R2 R4 R7: one byte per pixel, one column, gaps between bytes
        cfg_col = 10'd2; cfg_bpp = 2'd1; cfg_ncols = 3'd1;
        cfg_row_bytes = 12'd8; cfg_rows = 10'd3; cfg_base = 16'h0100;
        start_frame();
        for (int r = 0; r < 3; r++) send_row(r, 1);
        idle();
        check(done == 1, "R8 done after last row", done, 1);
        drain_and_check("R2 R7 pending writes");

        // R5: three-byte pixels, two columns owned
        cfg_col = 10'd1; cfg_bpp = 2'd3; cfg_ncols = 3'd2;
        cfg_row_bytes = 12'd12; cfg_rows = 10'd2; cfg_base = 16'h0040;
        start_frame();
        check(done == 0, "R9 done cleared", done, 0);
        send_row(0, 0);
        check(done == 0, "R8 done not early", done, 0);
        send_row(1, 0);
        idle();
        check(done == 1, "R8 done colour frame", done, 1);
        // R8: bytes after done are ignored
        for (int x = 0; x < 12; x++) send(8'hA0 + 8'(x), x == 0);
        idle();
        check(done == 1, "R8 done sticky", done, 1);
        drain_and_check("R5 R8 pending writes");

        // R3: mid-row resync keeps row index
        cfg_col = 10'd1; cfg_bpp = 2'd1; cfg_ncols = 3'd2;
        cfg_row_bytes = 12'd8; cfg_rows = 10'd2; cfg_base = 16'h2000;
        start_frame();
        for (int x = 0; x < 3; x++) send(8'h50 + 8'(x), x == 0);
        idle();
        send_row(0, 0);
        send_row(1, 1);
        idle();
        check(done == 1, "R3 done after resync", done, 1);
        drain_and_check("R3 pending writes");

        // R9: frame restart mid-frame, byte on frame_start cycle is pos 0 row 0
        cfg_col = 10'd0; cfg_bpp = 2'd2; cfg_ncols = 3'd1;
        cfg_row_bytes = 12'd6; cfg_rows = 10'd3; cfg_base = 16'h0300;
        start_frame();
        send_row(0, 0);
        send(8'h11, 1); send(8'h22, 0); send(8'h33, 0);
        @(negedge clk);
        frame_start = 1; row_start = 0; bus_valid = 1; bus_data = 8'h77;
        m_pos = 0; m_row = 0; m_done = 0;
        expq.push_back({16'h0300, 8'h77});
        m_pos = 1;
        send(8'h78, 0);
        for (int x = 2; x < 6; x++) send(8'h79 + 8'(x), 0);
        send_row(1, 0);
        send_row(2, 0);
        idle();
        check(done == 1, "R9 done after restarted frame", done, 1);
        drain_and_check("R9 pending writes");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule